// File: doc/BRIEF.md
# Matrix Keypad Scanner with Event Queue

The block scans an 8 by 8 key matrix and reads a separate bank of 8 special-function keys. Columns are pulled low one at a time and the row sense lines are read back, so a closed key shows up as a low row while its column is driven. A full sweep of the matrix plus the special keys forms one scan frame. A changed frame becomes the accepted key state only after it has been seen unchanged in a host-chosen number of further frames. Every key that differs between the accepted state and the state last reported produces one byte event. Each event goes into a 16-entry first-in first-out queue that the host drains with a pop strobe.

The column scanner runs a small state machine: `SC_DRIVE` holds the current column low for `SETTLE` clocks. It then moves to `SC_SAMPLE`, which captures that column's rows. From there it returns to `SC_DRIVE` for the next column, or goes to `SC_FRAME` after the last column. `SC_FRAME` releases all columns for one clock, samples the special keys, publishes the frame and returns to `SC_DRIVE`. The event emitter has two states. `EM_IDLE` waits for an accepted frame and moves to `EM_WALK`. `EM_WALK` visits all 72 keys, one per clock, special keys first, and returns to `EM_IDLE` after the last key.

An interrupt line tells the host that events are waiting or that an error has been flagged. Two error flags are provided. One reports a lost event because the queue was full. The other reports that more than two matrix keys are held at once.

Top module: `keyscan_queue`

## Requirements
- R1: At most one column line is low at any time. Each column is held low for SETTLE+1 clocks (SETTLE settle clocks plus one sample clock). Once per frame all columns are released for one clock.
- R2: An event byte has bit 7 = 1 for a press and 0 for a release. Bits 6:0 carry the key number: row*8+column for a matrix key, and 64+n for special key n.
- R3: Each key whose accepted state differs from its last reported state yields exactly one event. Within one accepted frame, special keys come out first in ascending n, then matrix keys in ascending number.
- R4: A changed frame is accepted only after db_count further identical frames (a db_count of 0 acts as 1). A change shorter than that produces no event.
- R5: The queue holds 16 events in arrival order. evt_byte shows the oldest event, and a pop removes it.
- R6: With the queue empty, evt_byte reads 0x00 and a pop has no effect.
- R7: An event that arrives while the queue holds 16 entries is dropped and err_fifo_ovr is set. The flag stays set until the next pop.
- R8: While the accepted matrix state has more than two keys pressed, err_key_ovr is high. Matrix events for that state are withheld and reported once the count drops to two or fewer.
- R9: While any special key is pressed in the accepted state, matrix changes are withheld. They are reported after the special events once no special key is held.
- R10: irq is high exactly when the queue is non-empty or an error flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_sense_n | input | 8 | Row sense lines, low when a key on the driven column is closed |
| sfk_n | input | 8 | Special-function key lines, low when pressed |
| db_count | input | 8 | Debounce count in frames |
| pop | input | 1 | Removes the oldest queued event |
| col_drive_n | output | 8 | Column drive lines, active low |
| evt_byte | output | 8 | Oldest queued event, 0x00 when empty |
| irq | output | 1 | Interrupt request |
| err_fifo_ovr | output | 1 | Queue overflow flag |
| err_key_ovr | output | 1 | More than two matrix keys held |

## Verification
The hardest case to reach is the withheld-then-released path. A matrix change must stay pending behind a held special key or a three-key overrun, and then come out in the correct order once the blocking condition ends. The bench models the keys as a physical switch matrix that answers the column drive. It steps the pressed set through these sequences, waiting several debounce windows per step. A reference model of reported state and queue contents predicts every byte popped afterwards. Overflow is reached by toggling one key nine times without popping.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;

    typedef enum logic [1:0] {
        SC_DRIVE,
        SC_SAMPLE,
        SC_FRAME
    } scan_state_e;

    typedef enum logic {
        EM_IDLE,
        EM_WALK
    } emit_state_e;

    function automatic int unsigned bits_set(input logic [63:0] v, input int unsigned n);
        int unsigned acc;
        acc = 0;
        for (int unsigned i = 0; i < n; i++) begin
            if (v[i]) acc++;
        end
        return acc;
    endfunction

endpackage

// File: rtl/keyscan_colscan.sv
module keyscan_colscan
    import keyscan_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int NSF    = 8,
    parameter int SETTLE = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ROWS-1:0]        row_sense_n,
    input  logic [NSF-1:0]         sfk_n,
    output logic [COLS-1:0]        col_drive_n,
    output logic [ROWS*COLS-1:0]   frame_mx,
    output logic [NSF-1:0]         frame_sf,
    output logic                   frame_valid
);
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int SW = (SETTLE > 1) ? $clog2(SETTLE) : 1;

    scan_state_e state, state_nx;
    logic [CW-1:0] col;
    logic [SW-1:0] cnt;
    logic [COLS-1:0][ROWS-1:0] snap;

    wire settle_done = (cnt == SW'(SETTLE - 1));
    wire last_col    = (col == CW'(COLS - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            SC_DRIVE:  if (settle_done) state_nx = SC_SAMPLE;
            SC_SAMPLE: state_nx = last_col ? SC_FRAME : SC_DRIVE;
            SC_FRAME:  state_nx = SC_DRIVE;
            default:   state_nx = SC_DRIVE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= SC_DRIVE;
            col   <= '0;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            unique case (state)
                SC_DRIVE:  cnt <= settle_done ? '0 : cnt + 1'b1;
                SC_SAMPLE: col <= last_col ? '0 : col + 1'b1;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            snap        <= '0;
            frame_sf    <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= (state == SC_FRAME);
            if (state == SC_SAMPLE) snap[col] <= ~row_sense_n;
            if (state == SC_FRAME)  frame_sf  <= ~sfk_n;
        end
    end

    always_comb begin
        col_drive_n = '1;
        if (state != SC_FRAME) col_drive_n[col] = 1'b0;
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            assign frame_mx[r*COLS + c] = snap[c][r];
        end
    end

    p_onecol_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~col_drive_n) <= 1);

    p_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> $past(col_drive_n) == '1);

endmodule

// File: rtl/keyscan_debounce.sv
module keyscan_debounce #(
    parameter int NMX = 64,
    parameter int NSF = 8,
    parameter int DBW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           frame_valid,
    input  logic [NMX-1:0] frame_mx,
    input  logic [NSF-1:0] frame_sf,
    input  logic [DBW-1:0] db_count,
    output logic           acc_stb,
    output logic [NMX-1:0] acc_mx,
    output logic [NSF-1:0] acc_sf
);
    logic [DBW-1:0] stable;
    logic [DBW-1:0] stable_nx;
    logic [DBW-1:0] thr;

    assign thr       = (db_count == '0) ? DBW'(1) : db_count;
    assign stable_nx = (stable == '1) ? stable : stable + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stable  <= '0;
            acc_mx  <= '0;
            acc_sf  <= '0;
            acc_stb <= 1'b0;
        end else begin
            acc_stb <= 1'b0;
            if (frame_valid) begin
                if (frame_mx == acc_mx && frame_sf == acc_sf) begin
                    stable  <= stable_nx;
                    acc_stb <= (stable_nx >= thr);
                end else begin
                    acc_mx <= frame_mx;
                    acc_sf <= frame_sf;
                    stable <= '0;
                end
            end
        end
    end

    p_accept_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_stb |-> $stable(acc_mx) && $stable(acc_sf));

endmodule

// File: rtl/keyscan_emitter.sv
module keyscan_emitter
    import keyscan_pkg::*;
#(
    parameter int NMX = 64,
    parameter int NSF = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_stb,
    input  logic [NMX-1:0] acc_mx,
    input  logic [NSF-1:0] acc_sf,
    output logic           push,
    output logic [7:0]     push_code,
    output logic           key_ovr
);
    localparam int NTOT = NMX + NSF;
    localparam int IW   = $clog2(NTOT);
    localparam int SFW  = (NSF > 1) ? $clog2(NSF) : 1;
    localparam int MXW  = (NMX > 1) ? $clog2(NMX) : 1;

    emit_state_e state, state_nx;
    logic [IW-1:0]  idx;
    logic [NMX-1:0] cap_mx, rep_mx;
    logic [NSF-1:0] cap_sf, rep_sf;
    logic           blocked;

    logic [SFW-1:0] sfi;
    logic [IW-1:0]  mxo;
    logic [MXW-1:0] mxi;
    logic           is_sf;
    logic           last_idx;

    assign is_sf    = (idx < IW'(NSF));
    assign sfi      = idx[SFW-1:0];
    assign mxo      = idx - IW'(NSF);
    assign mxi      = mxo[MXW-1:0];
    assign last_idx = (idx == IW'(NTOT - 1));

    always_comb begin
        state_nx = state;
        unique case (state)
            EM_IDLE: if (acc_stb) state_nx = EM_WALK;
            EM_WALK: if (last_idx) state_nx = EM_IDLE;
            default: state_nx = EM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= EM_IDLE;
            idx   <= '0;
        end else begin
            state <= state_nx;
            if (state == EM_WALK) idx <= last_idx ? '0 : idx + 1'b1;
        end
    end

    always_comb begin
        push      = 1'b0;
        push_code = 8'h00;
        if (state == EM_WALK) begin
            if (is_sf) begin
                if (cap_sf[sfi] != rep_sf[sfi]) begin
                    push      = 1'b1;
                    push_code = {cap_sf[sfi], 7'(NMX) + 7'(sfi)};
                end
            end else if (!blocked && cap_mx[mxi] != rep_mx[mxi]) begin
                push      = 1'b1;
                push_code = {cap_mx[mxi], 7'(mxi)};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_mx  <= '0;
            cap_sf  <= '0;
            rep_mx  <= '0;
            rep_sf  <= '0;
            blocked <= 1'b0;
            key_ovr <= 1'b0;
        end else begin
            if (state == EM_IDLE && acc_stb) begin
                cap_mx  <= acc_mx;
                cap_sf  <= acc_sf;
                key_ovr <= (bits_set(64'(acc_mx), NMX) > 2);
                blocked <= (|acc_sf) || (bits_set(64'(acc_mx), NMX) > 2);
            end
            if (push && is_sf)  rep_sf[sfi] <= cap_sf[sfi];
            if (push && !is_sf) rep_mx[mxi] <= cap_mx[mxi];
        end
    end

    p_sf_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && (|cap_sf)) |-> (push_code[6:0] >= 7'(NMX)));

    p_ovr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && key_ovr) |-> (push_code[6:0] >= 7'(NMX)));

endmodule

// File: rtl/keyscan_fifo.sv
module keyscan_fifo #(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_data,
    input  logic       pop,
    output logic [7:0] head_byte,
    output logic       not_empty,
    output logic       ovr_err
);
    localparam int AW = $clog2(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wr, rd;
    logic [AW:0]   count;
    logic          full, do_push, do_pop;

    assign full      = (count == (AW+1)'(DEPTH));
    assign not_empty = (count != '0);
    assign do_push   = push && !full;
    assign do_pop    = pop && not_empty;
    assign head_byte = not_empty ? mem[rd] : 8'h00;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr      <= '0;
            rd      <= '0;
            count   <= '0;
            ovr_err <= 1'b0;
        end else begin
            if (do_push) wr <= wr + 1'b1;
            if (do_pop)  rd <= rd + 1'b1;
            count <= count + (AW+1)'(do_push) - (AW+1)'(do_pop);
            if (push && full) ovr_err <= 1'b1;
            else if (pop)     ovr_err <= 1'b0;
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= (AW+1)'(DEPTH));

    p_drop_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> ovr_err);

    p_empty_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!not_empty && !push) |=> !not_empty);

endmodule

// File: rtl/keyscan_queue.sv
module keyscan_queue #(
    parameter int ROWS   = 8,
    parameter int COLS   = 8,
    parameter int NSF    = 8,
    parameter int DEPTH  = 16,
    parameter int SETTLE = 4,
    parameter int DBW    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ROWS-1:0] row_sense_n,
    input  logic [NSF-1:0]  sfk_n,
    input  logic [DBW-1:0]  db_count,
    input  logic            pop,
    output logic [COLS-1:0] col_drive_n,
    output logic [7:0]      evt_byte,
    output logic            irq,
    output logic            err_fifo_ovr,
    output logic            err_key_ovr
);
    localparam int NMX = ROWS * COLS;

    logic [NMX-1:0] frame_mx, acc_mx;
    logic [NSF-1:0] frame_sf, acc_sf;
    logic           frame_valid, acc_stb;
    logic           push, fifo_ne;
    logic [7:0]     push_code;

    keyscan_colscan #(.ROWS(ROWS), .COLS(COLS), .NSF(NSF), .SETTLE(SETTLE)) u_scan (
        .clk(clk), .rst_n(rst_n), .row_sense_n(row_sense_n), .sfk_n(sfk_n),
        .col_drive_n(col_drive_n), .frame_mx(frame_mx), .frame_sf(frame_sf),
        .frame_valid(frame_valid)
    );

    keyscan_debounce #(.NMX(NMX), .NSF(NSF), .DBW(DBW)) u_deb (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .frame_mx(frame_mx),
        .frame_sf(frame_sf), .db_count(db_count), .acc_stb(acc_stb),
        .acc_mx(acc_mx), .acc_sf(acc_sf)
    );

    keyscan_emitter #(.NMX(NMX), .NSF(NSF)) u_emit (
        .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_mx(acc_mx), .acc_sf(acc_sf),
        .push(push), .push_code(push_code), .key_ovr(err_key_ovr)
    );

    keyscan_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_code), .pop(pop),
        .head_byte(evt_byte), .not_empty(fifo_ne), .ovr_err(err_fifo_ovr)
    );

    assign irq = fifo_ne | err_fifo_ovr | err_key_ovr;

    p_push_raises_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> irq);

endmodule

// File: tb/test_keyscan_queue.sv
module test_keyscan_queue;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] row_sense_n;
    logic [7:0] sfk_n;
    logic [7:0] db_count = 8'd2;
    logic pop = 1'b0;
    logic [7:0] col_drive_n;
    logic [7:0] evt_byte;
    logic irq, err_fifo_ovr, err_key_ovr;

    logic [63:0] kp = '0;
    logic [7:0]  sfp = '0;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] m_rep_mx = '0;
    logic [7:0]  m_rep_sf = '0;
    logic [7:0]  m_q [$];
    bit          m_ovr = 0;

    always #10 clk = ~clk;

    keyscan_queue i_keyscan_queue (
        .clk(clk), .rst_n(rst_n), .row_sense_n(row_sense_n), .sfk_n(sfk_n),
        .db_count(db_count), .pop(pop), .col_drive_n(col_drive_n),
        .evt_byte(evt_byte), .irq(irq), .err_fifo_ovr(err_fifo_ovr),
        .err_key_ovr(err_key_ovr)
    );

    always_comb begin
        for (int r = 0; r < 8; r++) begin
            row_sense_n[r] = 1'b1;
            for (int c = 0; c < 8; c++) begin
                if (kp[r*8 + c] && !col_drive_n[c]) row_sense_n[r] = 1'b0;
            end
        end
        sfk_n = ~sfp;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk($countones(~col_drive_n) <= 1, "R1 one column low", int'(col_drive_n), 0);
            if (!irq) chk(evt_byte == 8'h00, "R6/R10 idle byte", int'(evt_byte), 0);
        end
    end

    function automatic int cnt64(input logic [63:0] v);
        int n = 0;
        for (int i = 0; i < 64; i++) if (v[i]) n++;
        return n;
    endfunction

    task automatic enq(input logic [7:0] code);
        if (m_q.size() == 16) m_ovr = 1;
        else m_q.push_back(code);
    endtask

    task automatic settle_wait();
        repeat ((int'(db_count) + 3) * 41 + 120) @(negedge clk);
    endtask

    task automatic step(input logic [63:0] nk, input logic [7:0] ns);
        bit blk;
        kp = nk;
        sfp = ns;
        blk = (|ns) || (cnt64(nk) > 2);
        for (int j = 0; j < 8; j++)
            if (ns[j] != m_rep_sf[j]) begin
                enq({ns[j], 7'(64 + j)});
                m_rep_sf[j] = ns[j];
            end
        if (!blk)
            for (int i = 0; i < 64; i++)
                if (nk[i] != m_rep_mx[i]) begin
                    enq({nk[i], 7'(i)});
                    m_rep_mx[i] = nk[i];
                end
        settle_wait();
    endtask

    task automatic pop_one(input string req);
        logic [7:0] exp;
        @(negedge clk);
        exp = (m_q.size() != 0) ? m_q.pop_front() : 8'h00;
        chk(evt_byte == exp, req, int'(evt_byte), int'(exp));
        pop = 1'b1;
        @(negedge clk);
        pop = 1'b0;
        m_ovr = 0;
    endtask

    task automatic drain(input string req);
        while (m_q.size() != 0) pop_one(req);
        @(negedge clk);
        chk(irq == (err_key_ovr | err_fifo_ovr), "R10 irq after drain", int'(irq), 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] k;
        repeat (3) @(negedge clk);
        chk(evt_byte == 8'h00, "R6 reset byte", int'(evt_byte), 0);
        chk(irq == 1'b0, "R10 reset irq", int'(irq), 0);
        chk({err_fifo_ovr, err_key_ovr} == 2'b00, "R7/R8 reset flags", int'({err_fifo_ovr, err_key_ovr}), 0);
        rst_n = 1'b1;
        settle_wait();
        chk(irq == 1'b0, "R10 idle irq", int'(irq), 0);

        // R2 single press / release: row 2 col 5 -> 0x95 / 0x15
        k = '0; k[21] = 1'b1;
        step(k, 8'h00);
        chk(irq == 1'b1, "R10 irq on event", int'(irq), 1);
        chk(evt_byte == 8'h95, "R2 press code", int'(evt_byte), 8'h95);
        step('0, 8'h00);
        drain("R2 R5 press/release order");

        // R6 pop on empty
        pop_one("R6 empty pop reads zero");
        chk(irq == 1'b0, "R6 empty pop no effect", int'(irq), 0);

        // R3 two keys in one frame ascending
        k = '0; k[40] = 1'b1; k[3] = 1'b1;
        step(k, 8'h00);
        step('0, 8'h00);
        drain("R3 ascending two keys");

        // R8 three keys: withheld, flag set
        k = '0; k[0] = 1'b1; k[9] = 1'b1; k[18] = 1'b1;
        step(k, 8'h00);
        chk(err_key_ovr == 1'b1, "R8 overrun flag", int'(err_key_ovr), 1);
        chk(evt_byte == 8'h00, "R8 withheld", int'(evt_byte), 0);
        k[18] = 1'b0;
        step(k, 8'h00);
        chk(err_key_ovr == 1'b0, "R8 overrun clear", int'(err_key_ovr), 0);
        step('0, 8'h00);
        drain("R8 release after overrun");

        // R9 special key priority
        step('0, 8'h08);
        k = '0; k[63] = 1'b1;
        step(k, 8'h08);
        chk(evt_byte == 8'hC3, "R9 only special event", int'(evt_byte), 8'hC3);
        step(k, 8'h00);
        step('0, 8'h01);
        step('0, 8'h00);
        drain("R9 R2 special then matrix");

        // R4 glitch shorter than debounce ignored
        db_count = 8'd3;
        settle_wait();
        kp[12] = 1'b1;
        repeat (20) @(negedge clk);
        kp[12] = 1'b0;
        settle_wait();
        chk(irq == 1'b0, "R4 glitch ignored", int'(irq), 0);
        db_count = 8'd0;
        k = '0; k[33] = 1'b1;
        step(k, 8'h00);
        step('0, 8'h00);
        drain("R4 zero count acts as one");
        db_count = 8'd2;

        // R7 overflow: 18 events into 16 slots
        k = '0; k[7] = 1'b1;
        for (int n = 0; n < 9; n++) begin
            step(k, 8'h00);
            step('0, 8'h00);
        end
        chk(err_fifo_ovr == 1'b1, "R7 overflow flag", int'(err_fifo_ovr), 1);
        chk(irq == 1'b1, "R10 irq on overflow", int'(irq), 1);
        pop_one("R7 oldest kept");
        chk(err_fifo_ovr == 1'b0, "R7 flag cleared by pop", int'(err_fifo_ovr), 0);
        drain("R5 R7 remaining fifo order");
        pop_one("R6 empty after drain");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule